// File: doc/BRIEF.md
# Byte-Split ADC Conversion Read Sequencer

This block runs a 12-bit successive-approximation data-acquisition converter that has three control and status wires. One control line is shared between starting a conversion and reading the result. A second line chooses which half of the result the converter drives onto an 8-bit data bus. The converter reports a busy status.

When a request arrives, the sequencer drives the shared line low and holds it low. It waits for the synchronized busy status to go high and then low again. It then releases the line and waits until the converter's outputs have left high impedance. It samples the upper eight bits, switches the byte selector and waits for the bus to settle. It then samples the low nibble. The joined 12-bit word is presented together with a one-cycle strobe.

Every minimum delay is a parameter counted in clock cycles, and a value below one is raised to one. If the converter never reports busy, a watchdog abandons the attempt and flags an error. With the default parameters at 250 MHz, each 13-cycle delay covers a 50 ns minimum.

Top module: `adc_read_seq`

## Requirements
- R1: After reset, `conv_n` is high, `byte_sel` is high, and `result_valid` and `timeout_err` are low.
- R2: A `start_req` seen while idle drives `conv_n` low on the next clock edge. `conv_n` then stays low for at least `LOW_CYC` cycles.
- R3: `conv_n` stays low until a falling edge of the synchronized busy status is detected, or until a timeout. Only then does it return high.
- R4: `busy_in` passes through two flops before it is used. `result_valid` rises on the edge numbered `HOLD_CYC+SETTLE_CYC+5`, where edge 1 is the first rising edge that samples `busy_in` low.
- R5: The upper byte is sampled with `byte_sel`=1 (1 selects the upper eight result bits, `bus_in[7]` = result bit 11). Sampling happens only after `conv_n` has been high for at least `HOLD_CYC` cycles.
- R6: For the low nibble, `byte_sel` is driven to 0. It is held at 0 for at least `SETTLE_CYC` cycles before sampling. The nibble is taken from `bus_in[3:0]` (`bus_in[0]` = result bit 0), and `bus_in[7:4]` is ignored in this phase.
- R7: `result` equals {upper byte, low nibble}. `result_valid` is high for exactly one cycle, and `result` holds its value afterwards.
- R8: A `start_req` that arrives while a conversion or read is in progress is ignored. It produces no second low pulse on `conv_n` and no extra result.
- R9: If busy is not seen high within `BUSY_TMO` cycles after the start-low phase ends, `timeout_err` pulses for one cycle. In that case `conv_n` returns high after exactly `LOW_CYC+BUSY_TMO` low cycles, and no result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request to begin one conversion |
| busy_in | input | 1 | Converter busy status, asynchronous |
| bus_in | input | 8 | Converter data bus |
| conv_n | output | 1 | Shared line: low starts a conversion, high allows reading |
| byte_sel | output | 1 | 1 selects the upper byte, 0 selects the low nibble |
| result | output | 12 | Assembled conversion word |
| result_valid | output | 1 | One-cycle strobe marking a new `result` |
| timeout_err | output | 1 | One-cycle pulse when busy never rose |

## Verification
The bound checker watches several cycle-level rules on every clock:
- The shared line falls only after a request.
- The shared line rises only after a detected busy fall or a timeout.
- The nibble selector is only ever low while the line is high.
- The valid and error strobes each last one cycle and never coincide.

The checker cannot see whether the delays were long enough or the bytes were assembled correctly. The bench's converter model shows this by driving a poison value until each wait has elapsed. The bench also measures the exact latency after the busy fall, the timeout pulse length and the rejection of overlapping requests.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_WAIT_HI,
    S_WAIT_LO,
    S_RELEASE,
    S_RD_HI,
    S_SWITCH,
    S_RD_LO,
    S_DONE
  } seq_state_t;

  // A programmed delay never drops below one cycle.
  function automatic int clamp1(input int cyc);
    return (cyc < 1) ? 1 : cyc;
  endfunction

  // Counter width able to hold the largest of four delays.
  function automatic int delay_width(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_async,
  output logic busy_lvl,
  output logic busy_fall
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= busy_async;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign busy_lvl  = sync_q;
  assign busy_fall = last_q & ~sync_q;
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/adc_word_capture.sv
module adc_word_capture #(
  parameter int BUS_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_hi,
  input  logic              cap_lo,
  input  logic [BUS_W-1:0]  bus,
  output logic [DATA_W-1:0] word
);
  localparam int LO_W = DATA_W - BUS_W;

  logic [BUS_W-1:0]  hi_q;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      word_q <= '0;
    end else begin
      if (cap_hi) hi_q   <= bus;
      if (cap_lo) word_q <= {hi_q, bus[LO_W-1:0]};
    end
  end

  assign word = word_q;
endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
  import adc_seq_pkg::*;
#(
  parameter int LOW_CYC    = 13,
  parameter int HOLD_CYC   = 13,
  parameter int SETTLE_CYC = 13,
  parameter int BUSY_TMO   = 100,
  parameter int BUS_W      = 8,
  parameter int DATA_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              busy_in,
  input  logic [BUS_W-1:0]  bus_in,
  output logic              conv_n,
  output logic              byte_sel,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              timeout_err
);
  localparam int LOW_E    = clamp1(LOW_CYC);
  localparam int HOLD_E   = clamp1(HOLD_CYC);
  localparam int SETTLE_E = clamp1(SETTLE_CYC);
  localparam int TMO_E    = clamp1(BUSY_TMO);
  localparam int TW       = delay_width(LOW_E, HOLD_E, SETTLE_E, TMO_E);

  seq_state_t    state_q, nxt;
  logic          busy_lvl, busy_fall;
  logic          tmr_zero, tmr_load;
  logic [TW-1:0] tmr_val;
  logic          err_q;
  logic          timeout_hit;

  adc_busy_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_async (busy_in),
    .busy_lvl   (busy_lvl),
    .busy_fall  (busy_fall)
  );

  adc_seq_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  assign timeout_hit = (state_q == S_WAIT_HI) && !busy_lvl && tmr_zero;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      S_IDLE:    if (start_req) nxt = S_START;
      S_START:   if (tmr_zero) nxt = S_WAIT_HI;
      S_WAIT_HI: if (busy_lvl) nxt = S_WAIT_LO;
                 else if (tmr_zero) nxt = S_IDLE;
      S_WAIT_LO: if (busy_fall) nxt = S_RELEASE;
      S_RELEASE: if (tmr_zero) nxt = S_RD_HI;
      S_RD_HI:   nxt = S_SWITCH;
      S_SWITCH:  if (tmr_zero) nxt = S_RD_LO;
      S_RD_LO:   nxt = S_DONE;
      S_DONE:    nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (nxt)
      S_START:   tmr_val = TW'(LOW_E - 1);
      S_WAIT_HI: tmr_val = TW'(TMO_E - 1);
      S_RELEASE: tmr_val = TW'(HOLD_E - 1);
      S_SWITCH:  tmr_val = TW'(SETTLE_E - 1);
      default:   tmr_val = '0;
    endcase
  end

  assign tmr_load = (nxt != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      err_q   <= timeout_hit;
    end
  end

  adc_word_capture #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_hi (state_q == S_RD_HI),
    .cap_lo (state_q == S_RD_LO),
    .bus    (bus_in),
    .word   (result)
  );

  assign conv_n       = !((state_q == S_START) || (state_q == S_WAIT_HI) ||
                          (state_q == S_WAIT_LO));
  assign byte_sel     = !((state_q == S_SWITCH) || (state_q == S_RD_LO));
  assign result_valid = (state_q == S_DONE);
  assign timeout_err  = err_q;
endmodule

// File: rtl/adc_read_seq_chk.sv
module adc_read_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_req,
  input logic conv_n,
  input logic byte_sel,
  input logic result_valid,
  input logic timeout_err,
  input logic busy_fall
);
  // R2: the shared line only falls in answer to a request
  p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_n) |-> $past(start_req));

  // R3: the line is released only after a busy fall or on timeout
  p_release_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_n) |-> ($past(busy_fall) || timeout_err));

  // R6: the nibble is selected only while the line is high
  p_nibble_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_sel |-> conv_n);

  // R5: no result is presented while the outputs would be high impedance
  p_no_read_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> conv_n);

  // R7: valid is a single-cycle strobe
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R9: error is a single-cycle strobe and excludes a result
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> !timeout_err);
  p_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeout_err && result_valid));
endmodule

bind adc_read_seq adc_read_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_req    (start_req),
  .conv_n       (conv_n),
  .byte_sel     (byte_sel),
  .result_valid (result_valid),
  .timeout_err  (timeout_err),
  .busy_fall    (busy_fall)
);

// File: tb/adc_read_seq_bench.sv
module adc_read_seq_bench;
  localparam int LOW    = 13;
  localparam int HOLD   = 13;
  localparam int SETTLE = 13;
  localparam int TMO    = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_req = 1'b0;
  logic        busy_in = 1'b0;
  logic [7:0]  bus_in;
  logic        conv_n, byte_sel, result_valid, timeout_err;
  logic [11:0] result;

  int tests = 0, fails = 0, cyc = 0;

  // converter model and monitor state
  logic [11:0] m_val = '0;
  int  m_dly = 50, m_len = 100, m_ph = 0, m_t = 0;
  bit  m_noresp = 1'b0;
  bit  prev_conv = 1'b1;
  int  hi_cnt = 0, lo_cnt = 0, low_run = 0, last_low = 0;
  int  valid_cnt = 0, err_cnt = 0, fall_cnt = 0;
  bit  lat_on = 1'b0, drop_low = 1'b0;
  int  lat = 0, got_lat = 0;

  always #2 clk = ~clk;

  adc_read_seq #(
    .LOW_CYC(LOW), .HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE), .BUSY_TMO(TMO),
    .BUS_W(8), .DATA_W(12)
  ) u_adc_read_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .busy_in(busy_in),
    .bus_in(bus_in), .conv_n(conv_n), .byte_sel(byte_sel), .result(result),
    .result_valid(result_valid), .timeout_err(timeout_err)
  );

  // Bus is poisoned until each required wait has elapsed.
  assign bus_in = (!conv_n || hi_cnt < HOLD + 1) ? 8'hEE :
                  byte_sel ? m_val[11:4] :
                  (lo_cnt < SETTLE + 1) ? 8'hEE : {4'hC, m_val[3:0]};

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (result_valid) valid_cnt++;
      if (timeout_err) err_cnt++;
      if (prev_conv && !conv_n) fall_cnt++;
      if (!conv_n) low_run++;
      else begin
        if (low_run > 0) last_low = low_run;
        low_run = 0;
      end
      hi_cnt = conv_n ? hi_cnt + 1 : 0;
      lo_cnt = !byte_sel ? lo_cnt + 1 : 0;
      if (lat_on) begin
        lat++;
        if (result_valid) begin got_lat = lat; lat_on = 1'b0; end
      end
      case (m_ph)
        0: if (prev_conv && !conv_n && !m_noresp) begin m_ph = 1; m_t = 0; end
        1: begin
          m_t++;
          if (m_t >= m_dly) begin busy_in = 1'b1; m_ph = 2; m_t = 0; end
        end
        default: begin
          m_t++;
          if (m_t >= m_len) begin
            busy_in = 1'b0; drop_low = !conv_n;
            lat_on = 1'b1; lat = 0; got_lat = 0; m_ph = 0;
          end
        end
      endcase
      prev_conv = conv_n;
    end
    if (cyc == 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic wait_end(input int v0, input int e0);
    for (int n = 0; n < 5000 && valid_cnt == v0 && err_cnt == e0; n++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 conv_n in reset", conv_n, 1);
    check("R1 byte_sel in reset", byte_sel, 1);
    check("R1 valid in reset", result_valid, 0);
    check("R1 err in reset", timeout_err, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 conv_n after reset", conv_n, 1);
  endtask

  task automatic t_convert(input logic [11:0] val, input int dly, input int len);
    int v0, e0, f0;
    m_val = val; m_dly = dly; m_len = len; m_noresp = 1'b0;
    v0 = valid_cnt; e0 = err_cnt; f0 = fall_cnt;
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    check("R2 conv_n low after request", conv_n, 0);
    wait_end(v0, e0);
    check("R7 one valid strobe", valid_cnt - v0, 1);
    check("R9 no error on good run", err_cnt - e0, 0);
    check("R2 one low pulse", fall_cnt - f0, 1);
    check("R2 low at least LOW_CYC", int'(last_low >= LOW), 1);
    check("R3 line low when busy fell", drop_low, 1);
    check("R4 latency after busy fall", got_lat, HOLD + SETTLE + 5);
    check("R5 upper byte", result[11:4], val[11:4]);
    check("R6 low nibble", result[3:0], val[3:0]);
    check("R7 full word", result, val);
    repeat (10) @(negedge clk);
    check("R7 word held", result, val);
  endtask

  task automatic t_overlap(input logic [11:0] val);
    int v0, e0, f0;
    m_val = val; m_dly = 50; m_len = 100; m_noresp = 1'b0;
    v0 = valid_cnt; e0 = err_cnt; f0 = fall_cnt;
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    for (int n = 0; n < 1000 && !conv_n; n++) @(negedge clk);
    pulse_start();
    repeat (HOLD + 2) @(negedge clk);
    pulse_start();
    wait_end(v0, e0);
    check("R8 single low pulse", fall_cnt - f0, 1);
    check("R8 single result", valid_cnt - v0, 1);
    check("R8 result intact", result, val);
  endtask

  task automatic t_timeout();
    int v0, e0;
    m_noresp = 1'b1;
    v0 = valid_cnt; e0 = err_cnt;
    pulse_start();
    wait_end(v0, e0);
    repeat (20) @(negedge clk);
    check("R9 one error pulse", err_cnt - e0, 1);
    check("R9 no result", valid_cnt - v0, 0);
    check("R9 low length", last_low, LOW + TMO);
    check("R9 line released", conv_n, 1);
    m_noresp = 1'b0;
  endtask

  initial begin
    t_reset();
    t_convert(12'hA5C, 50, 100);
    t_convert(12'hFFF, 50, 100);
    t_convert(12'h000, 30, 200);
    t_convert(12'h801, 1, 40);
    t_convert(12'h00F, 80, 60);
    t_overlap(12'h3C6);
    t_timeout();
    t_convert(12'h5A3, 50, 100);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule